// File: doc/BRIEF.md
# ALU Status Flag Generator

This unit sits beside an ALU and turns each completed operation into a set of status flags. On every clock it can take in both operands, the result the ALU produced, an operation class (add, subtract or logical) and a width select (8 or 16 bits). From these it derives carry/borrow, signed overflow, sign, zero, a nibble carry and low-byte parity. It writes them into a 16-bit flags register in which each flag has a fixed bit.

The same register holds three control flags: direction, interrupt and trap. These change only through dedicated set and clear strobes, and ALU traffic never touches them. A write enable lets instructions that leave the flags alone pass through with no effect. The arithmetic itself is done elsewhere. This unit only observes operands and result.

Top module: `status_flag_unit`

## Requirements
- R1: The `flags` output has carry at bit 0, parity at bit 2, nibble carry at bit 4, zero at bit 6, sign at bit 7, trap at bit 8, interrupt at bit 9, direction at bit 10 and overflow at bit 11. Every other bit reads 0.
- R2: The `opClass` input selects the operation: 0 is add, 1 is subtract, 2 is logical and 3 is reserved. On an add, carry is 1 when the unsigned sum does not fit the selected width. On a subtract, carry is 1 when the subtrahend is larger than the minuend as unsigned values, which is a borrow.
- R3: Overflow is set on an add when both operands share a sign and the result's sign differs from it. It is set on a subtract when the operand signs differ and the result's sign differs from the minuend's.
- R4: Sign is the result's top bit at the selected width, and zero is set when the result is 0 at that width. With `wide`=0 only bits 7:0 of the operands and the result count, and bits 15:8 have no effect.
- R5: On add and subtract, the nibble carry flag records a carry out of bit 3 into bit 4, or a borrow from bit 4 into bit 3.
- R6: Parity is 1 when bits 7:0 of the result hold an even number of ones, at both widths.
- R7: A logical operation clears carry and overflow, updates sign, zero and parity, and leaves the nibble carry flag unchanged.
- R8: With `flagWe` low, or with the reserved class 3, no status flag changes.
- R9: Control flags change only through `ctlSet` and `ctlClr`, where bit 0 is trap, bit 1 is interrupt and bit 2 is direction. When both strobes are high for the same flag, the set wins. A control strobe and a status update in the same cycle both take effect.
- R10: Updates are registered and appear one clock after the inputs. An active-low asynchronous reset clears the whole register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 16 | First operand (minuend for subtract) |
| opB | input | 16 | Second operand (subtrahend for subtract) |
| result | input | 16 | Result produced by the ALU |
| opClass | input | 2 | 0 add, 1 subtract, 2 logical, 3 reserved |
| wide | input | 1 | 1 selects 16-bit width, 0 selects 8-bit width |
| flagWe | input | 1 | Status flag write enable |
| ctlSet | input | 3 | Set strobes: bit 0 trap, bit 1 interrupt, bit 2 direction |
| ctlClr | input | 3 | Clear strobes, same bit order as ctlSet |
| flags | output | 16 | Flags register |

## Verification
Two things can land in the same cycle: a status flag update from an ALU result and a control strobe. A set and a clear aimed at the same control flag can also coincide. The bench drives an arithmetic write together with control strobes, and separately raises set and clear for one flag at once. It then compares the whole register one clock later against a model that applies both effects, with the set winning. This confirms that neither path overwrites the other's bits.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int FLAG_W = 16;
  localparam int PAR_W  = 8;

  localparam int CF_BIT = 0;
  localparam int PF_BIT = 2;
  localparam int AF_BIT = 4;
  localparam int ZF_BIT = 6;
  localparam int SF_BIT = 7;
  localparam int TF_BIT = 8;
  localparam int IF_BIT = 9;
  localparam int DF_BIT = 10;
  localparam int OF_BIT = 11;

  localparam int CTL_N = 3;
  // control strobe index -> register bit (0 trap, 1 interrupt, 2 direction)
  localparam int CTL_POS [CTL_N] = '{TF_BIT, IF_BIT, DF_BIT};

  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_SUB   = 2'd1,
    OP_LOGIC = 2'd2,
    OP_RSVD  = 2'd3
  } opClass_e;

  typedef struct packed {
    logic             loadStatus;
    logic             loadAux;
    logic             subMode;
    logic             logicMode;
    logic [CTL_N-1:0] ctlLoad;
    logic [CTL_N-1:0] ctlVal;
  } strobe_t;
endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_pkg::*;
(
  input  logic             flagWe,
  input  logic [1:0]       opClass,
  input  logic [CTL_N-1:0] ctlSet,
  input  logic [CTL_N-1:0] ctlClr,
  output strobe_t          strobe
);
  always_comb begin
    strobe = '0;
    unique case (opClass_e'(opClass))
      OP_ADD: begin
        strobe.loadStatus = flagWe;
        strobe.loadAux    = flagWe;
      end
      OP_SUB: begin
        strobe.loadStatus = flagWe;
        strobe.loadAux    = flagWe;
        strobe.subMode    = 1'b1;
      end
      OP_LOGIC: begin
        strobe.loadStatus = flagWe;
        strobe.logicMode  = 1'b1;
      end
      default: ;
    endcase
    // set has priority over clear
    strobe.ctlLoad = ctlSet | ctlClr;
    strobe.ctlVal  = ctlSet;
  end
endmodule

// File: rtl/flag_path.sv
module flag_path
  import flag_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] result,
  input  logic              wide,
  input  strobe_t           strobe,
  output logic [FLAG_W-1:0] flags
);
  logic [FLAG_W-1:0]   flagsQ, flagsNxt;
  logic [DATA_W:0]     sumWide;
  logic [NARROW_W:0]   sumNarrow;
  logic carryAdd, borrow, aMsb, bMsb, rMsb, ovfAdd, ovfSub, isZero, parEven, auxCarry;

  always_comb begin
    sumWide   = {1'b0, opA} + {1'b0, opB};
    sumNarrow = {1'b0, opA[NARROW_W-1:0]} + {1'b0, opB[NARROW_W-1:0]};
    carryAdd  = wide ? sumWide[DATA_W] : sumNarrow[NARROW_W];
    borrow    = wide ? (opA < opB) : (opA[NARROW_W-1:0] < opB[NARROW_W-1:0]);
    aMsb      = wide ? opA[DATA_W-1]    : opA[NARROW_W-1];
    bMsb      = wide ? opB[DATA_W-1]    : opB[NARROW_W-1];
    rMsb      = wide ? result[DATA_W-1] : result[NARROW_W-1];
    ovfAdd    = (aMsb == bMsb) && (rMsb != aMsb);
    ovfSub    = (aMsb != bMsb) && (rMsb != aMsb);
    isZero    = wide ? (result == '0) : (result[NARROW_W-1:0] == '0);
    parEven   = ~^result[PAR_W-1:0];
    auxCarry  = opA[4] ^ opB[4] ^ result[4];
  end

  always_comb begin
    flagsNxt = flagsQ;
    if (strobe.loadStatus) begin
      flagsNxt[CF_BIT] = strobe.logicMode ? 1'b0 : (strobe.subMode ? borrow : carryAdd);
      flagsNxt[OF_BIT] = strobe.logicMode ? 1'b0 : (strobe.subMode ? ovfSub : ovfAdd);
      flagsNxt[SF_BIT] = rMsb;
      flagsNxt[ZF_BIT] = isZero;
      flagsNxt[PF_BIT] = parEven;
    end
    if (strobe.loadAux) flagsNxt[AF_BIT] = auxCarry;
    for (int i = 0; i < CTL_N; i++) begin
      if (strobe.ctlLoad[i]) flagsNxt[CTL_POS[i]] = strobe.ctlVal[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= flagsNxt;
  end

  assign flags = flagsQ;
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import flag_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] result,
  input  logic [1:0]        opClass,
  input  logic              wide,
  input  logic              flagWe,
  input  logic [2:0]        ctlSet,
  input  logic [2:0]        ctlClr,
  output logic [15:0]       flags
);
  strobe_t strobe;

  flag_ctrl ctrl_i (
    .flagWe (flagWe),
    .opClass(opClass),
    .ctlSet (ctlSet),
    .ctlClr (ctlClr),
    .strobe (strobe)
  );

  flag_path #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) path_i (
    .clk   (clk),
    .rstN  (rstN),
    .opA   (opA),
    .opB   (opB),
    .result(result),
    .wide  (wide),
    .strobe(strobe),
    .flags (flags)
  );
endmodule

// File: rtl/flag_checker.sv
module flag_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        opClass,
  input logic              flagWe,
  input logic [2:0]        ctlSet,
  input logic [2:0]        ctlClr,
  input logic [15:0]       flags
);
  localparam logic [15:0] USED_MASK = 16'h0FD5;

  assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (flags & ~USED_MASK) == 16'h0000);

  assert_logic_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (flagWe && opClass == 2'd2) |=> (flags[0] == 1'b0 && flags[11] == 1'b0));

  assert_logic_keeps_aux_R7: assert property (@(posedge clk) disable iff (!rstN)
    (flagWe && opClass == 2'd2) |=> $stable(flags[4]));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!(flagWe && opClass != 2'd3) && ctlSet == 3'b000 && ctlClr == 3'b000) |=> $stable(flags));

  assert_ctl_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctlSet == 3'b000 && ctlClr == 3'b000) |=> $stable(flags[10:8]));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctlSet != 3'b000) |=> ((flags[10:8] & $past(ctlSet)) == $past(ctlSet)));
endmodule

bind status_flag_unit flag_checker #(.DATA_W(DATA_W)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .opClass(opClass),
  .flagWe (flagWe),
  .ctlSet (ctlSet),
  .ctlClr (ctlClr),
  .flags  (flags)
);

// File: tb/status_flag_unit_tb_top.sv
`timescale 1ns/1ps
module status_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = '0, opB = '0, result = '0;
  logic [1:0]  opClass = '0;
  logic        wide = 1'b0, flagWe = 1'b0;
  logic [2:0]  ctlSet = '0, ctlClr = '0;
  logic [15:0] flags;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [15:0] expFlags = '0;
  logic [15:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  status_flag_unit dut_i (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .result(result),
    .opClass(opClass), .wide(wide), .flagWe(flagWe),
    .ctlSet(ctlSet), .ctlClr(ctlClr), .flags(flags)
  );

  task automatic checkNow(string tag, logic [15:0] exp);
    checks++;
    if (flags !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, flags, exp);
    end
  endtask

  // monitor: one cycle after each driven item, compare
  always begin
    @(posedge clk);
    #1;
    if (expQ.size() > 0) begin
      logic [15:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checkNow(t, e);
    end
  end

  // driver: compute expected per requirements, apply inputs, push expectation
  task automatic drive(int op, bit w, int a, int b, bit we,
                       logic [2:0] s, logic [2:0] c, bit junkHigh, string tag);
    int mask, half, ua, ub, r, rm, sa, sb, sr;
    bit cf, of, af;
    logic [15:0] e;
    logic [15:0] resBus;
    mask = w ? 32'hFFFF : 32'hFF;
    half = w ? 32768 : 128;
    ua = a & mask; ub = b & mask;
    sa = (ua >= half) ? ua - 2*half : ua;
    sb = (ub >= half) ? ub - 2*half : ub;
    cf = 0; of = 0; af = 0; r = 0;
    case (op)
      0: begin r = ua + ub; cf = r > mask; sr = sa + sb;
               of = (sr > half-1) || (sr < -half); af = ((ua & 15) + (ub & 15)) > 15; end
      1: begin r = ua - ub; cf = ua < ub; sr = sa - sb;
               of = (sr > half-1) || (sr < -half); af = (ua & 15) < (ub & 15); end
      default: r = ua & ub;
    endcase
    rm = r & mask;
    e = expFlags;
    if (we && op != 3) begin
      e[0]  = (op == 2) ? 1'b0 : cf;
      e[11] = (op == 2) ? 1'b0 : of;
      e[7]  = rm >= half;
      e[6]  = rm == 0;
      e[2]  = ($countones(rm & 255) % 2) == 0;
      if (op != 2) e[4] = af;
    end
    for (int i = 0; i < 3; i++) begin
      int pos = 8 + i;
      if (s[i]) e[pos] = 1'b1;
      else if (c[i]) e[pos] = 1'b0;
    end
    resBus = rm[15:0];
    @(negedge clk);
    opA = a[15:0]; opB = b[15:0];
    if (!w && junkHigh) begin
      opA[15:8] = 8'hC3; opB[15:8] = 8'h5A; resBus[15:8] = 8'h96;
    end
    result = resBus;
    opClass = op[1:0]; wide = w; flagWe = we; ctlSet = s; ctlClr = c;
    expFlags = e;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic idleDrive(string tag);
    drive(0, 0, 0, 0, 0, 3'b000, 3'b000, 0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkNow("R10 reset clears", 16'h0000);
    rstN = 1'b1;
    // R2 R6 plain narrow add; R4 sign/zero
    drive(0, 0, 'h12, 'h34, 1, 0, 0, 0, "R6 add8 0x12+0x34");
    drive(0, 0, 'hFF, 'h01, 1, 0, 0, 0, "R2 R5 add8 carry 0xFF+1");
    drive(0, 0, 'h7F, 'h01, 1, 0, 0, 0, "R3 add8 overflow 0x7F+1");
    drive(1, 0, 'h00, 'h01, 1, 0, 0, 0, "R2 R5 sub8 borrow 0-1");
    drive(1, 0, 'h80, 'h01, 1, 0, 0, 0, "R3 sub8 overflow 0x80-1");
    drive(0, 1, 'hFFFF, 'h0001, 1, 0, 0, 0, "R2 add16 carry");
    drive(0, 1, 'h7FFF, 'h0001, 1, 0, 0, 0, "R3 R4 add16 overflow sign");
    drive(1, 1, 'h1234, 'h1234, 1, 0, 0, 0, "R4 sub16 zero");
    drive(1, 1, 'h0100, 'h8000, 1, 0, 0, 0, "R3 sub16 diff signs");
    drive(0, 0, 'h1280, 'h3480, 1, 0, 0, 1, "R4 narrow ignores upper bits");
    drive(0, 0, 'h0F, 'h01, 1, 0, 0, 0, "R5 add8 nibble carry");
    drive(2, 0, 'hF0, 'h0F, 1, 0, 0, 0, "R7 logic keeps aux, zero");
    drive(2, 1, 'hFFFF, 'h8001, 1, 0, 0, 0, "R7 logic16 sign parity");
    drive(0, 0, 'hFF, 'hFF, 0, 0, 0, 0, "R8 write enable low holds");
    drive(3, 0, 'h00, 'h00, 1, 0, 0, 0, "R8 reserved class holds");
    drive(0, 0, 0, 0, 0, 3'b111, 3'b000, 0, "R9 set all control");
    drive(0, 0, 0, 0, 0, 3'b000, 3'b001, 0, "R9 clear trap");
    drive(0, 0, 0, 0, 0, 3'b100, 3'b110, 0, "R9 set wins over clear");
    drive(0, 0, 'h80, 'h80, 1, 3'b001, 3'b010, 0, "R9 R1 control with arithmetic");
    drive(1, 0, 'h05, 'h03, 1, 0, 0, 0, "R9 arithmetic leaves control");
    idleDrive("R8 idle hold");
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    expFlags = '0;
    #1;
    checkNow("R10 reset mid-run", 16'h0000);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkNow("R10 stays clear after reset", 16'h0000);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule